// File: doc/BRIEF.md
# Serial Control-Register Access Master

This block is the host-side engine for reaching control registers of devices on a daisy-chained serial port. The host places a request on its inputs: an opcode, a device number, a broadcast flag, a register address and write data. It then pulses `start`. The engine builds the serial clock from the system clock, marks the start of the transaction on the command line, and shifts four 16-bit packets out on the data pin. The packets go out in the order that the opcode requires.

For a read, the engine drives the request, address and interval packets. It then releases the data pin and listens for the return frame from the chain. The frame is a zero start bit, sixteen data bits with the most significant bit first, and a zero trailing bit. When the transaction ends, the engine raises a one-cycle `done` together with the read data and an error flag. While the engine is busy it ignores further start requests. It refuses a broadcast read outright.

Top module: `sra_master`

## Requirements
- R1: After reset: `busy`, `done`, `err`, `sck`, `cmd` and `sdo` are 0, `rdata` is 0 and `sdo_oe` is 1.
- R2: While busy, each bit slot lasts CLK_DIV system cycles, and `sck` is high for the first CLK_DIV/2 cycles of the slot and low for the rest. While idle, `sck` stays low.
- R3: `cmd` is high during slots 0 and 1 of a transaction and low at every other time. Across the half-periods of the first four slots, this gives the pattern 11110000.
- R4: Every packet is sent most significant bit first, with one bit per slot. A bit changes only at the start of its slot, so it is stable across the falling edge. The request packet is {opcode[3:0], device[5:0], broadcast, 5'b00000}, and the address packet is {4'b0000, address[11:0]}.
- R5: Any opcode other than 4'h2 is a write. A write sends request, address, write data and an all-zero interval packet, which is 64 slots in all. `busy` is high for exactly 64*CLK_DIV cycles and `done` pulses in the first idle cycle.
- R6: Opcode 4'h2 is a read. A read sends request, address and an all-zero interval packet. From slot 48 onward it holds `sdo_oe` low until the transaction ends.
- R7: During the read window, `sdi` is sampled in the last cycle of the high half... more precisely, in the first cycle after each falling edge of `sck`. Ones are skipped until the first 0 is sampled. The next 16 samples form `rdata`, most significant bit first. The sample after them is the trailing bit. `done` follows one cycle after that sample.
- R8: If the trailing bit is 1, the transaction ends with `err` = 1 and `rdata` = 0.
- R9: If a complete frame has not been received within RD_WIN samples, the transaction ends after sample RD_WIN with `err` = 1 and `rdata` = 0.
- R10: A `start` pulse that arrives while `busy` is high has no effect on the transaction in progress or on its length.
- R11: A read with the broadcast flag set sends nothing. `busy` and `sck` stay low, and `done` and `err` are both 1 in the next cycle.
- R12: While idle, the engine drives `sdo` = 0 with `sdo_oe` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; taken only while idle |
| op | input | 4 | Opcode; 4'h2 selects a read |
| dev | input | 6 | Target device number |
| bcast | input | 1 | Broadcast flag |
| reg_addr | input | 12 | Control-register address |
| wdata | input | 16 | Data for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error status, valid with `done` |
| rdata | output | 16 | Read data, valid with `done` |
| sck | output | 1 | Serial clock |
| cmd | output | 1 | Framing line |
| sdo | output | 1 | Serial data toward the chain |
| sdo_oe | output | 1 | Output enable for `sdo` |
| sdi | input | 1 | Serial data returning from the chain |

## Verification
Several internal faults show at the pins within one slot. A phase counter that slips moves an `sck` edge. A wrong slot count misplaces `cmd`. A wrong packet select flips an `sdo` bit, and all of these mismatch in the very cycle where the bench predicts the edge or bit. A receiver that locks on the wrong sample or shifts the wrong number of bits gives a wrong `rdata` or `err` at `done`. The same fault also moves `done` away from the predicted cycle, which is detected at most one serial period later. Faults in state sequencing appear as `busy` or `sdo_oe` changing in a cycle other than the one predicted for the opcode.

// File: rtl/sra_pkg.sv
package sra_pkg;

  localparam int OP_W   = 4;
  localparam int DEV_W  = 6;
  localparam int REG_W  = 12;
  localparam int DAT_W  = 16;
  localparam int PKT_W  = 16;
  localparam int N_PKT  = 4;

  localparam logic [OP_W-1:0] OP_READ = 4'h2;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [DEV_W-1:0] dev;
    logic             bcast;
    logic [REG_W-1:0] addr;
    logic [DAT_W-1:0] wdata;
  } sra_req_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } sra_state_t;

  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_DATA = 2'd1,
    RX_STOP = 2'd2
  } sra_rx_t;

  // Request packet: opcode, device, broadcast, zero fill.
  function automatic logic [PKT_W-1:0] req_word(input sra_req_t r);
    return {r.op, r.dev, r.bcast, {(PKT_W-OP_W-DEV_W-1){1'b0}}};
  endfunction

endpackage

// File: rtl/sra_rst_sync.sv
module sra_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/sra_clkdiv.sv
module sra_clkdiv #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic fall_tick,
  output logic slot_end
);

  localparam int HALF = DIV / 2;
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PH_HALF = PW'(HALF);
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (!run)                ph_d = '0;
    else if (ph_q == PH_LAST) ph_d = '0;
    else                     ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign sck       = run && (ph_q < PH_HALF);
  assign fall_tick = run && (ph_q == PH_HALF);
  assign slot_end  = run && (ph_q == PH_LAST);

endmodule

// File: rtl/sra_rx.sv
module sra_rx
  import sra_pkg::*;
#(
  parameter int WIN = 24,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sample,
  input  logic          sdi,
  output logic          fin,
  output logic          bad,
  output logic [DW-1:0] data
);

  localparam int WW = $clog2(WIN + 1);
  localparam int CW = $clog2(DW);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  sra_rx_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [WW-1:0] win_q, win_d;
  logic [DW-1:0] sh_q, sh_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    win_d = win_q;
    sh_d  = sh_q;
    fin   = 1'b0;
    bad   = 1'b0;
    if (clear) begin
      st_d  = RX_HUNT;
      cnt_d = '0;
      win_d = '0;
      sh_d  = '0;
    end else if (sample) begin
      win_d = win_q + 1'b1;
      unique case (st_q)
        RX_HUNT: begin
          if (!sdi) begin
            st_d  = RX_DATA;
            cnt_d = '0;
          end
        end
        RX_DATA: begin
          sh_d  = {sh_q[DW-2:0], sdi};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) st_d = RX_STOP;
        end
        RX_STOP: begin
          fin  = 1'b1;
          bad  = sdi;
          st_d = RX_HUNT;
        end
        default: st_d = RX_HUNT;
      endcase
      if (!fin && (win_q == WIN_LAST)) begin
        fin  = 1'b1;
        bad  = 1'b1;
        st_d = RX_HUNT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_HUNT;
      cnt_q <= '0;
      win_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      win_q <= win_d;
      sh_q  <= sh_d;
    end
  end

  assign data = sh_q;

endmodule

// File: rtl/sra_master.sv
module sra_master
  import sra_pkg::*;
#(
  parameter int CLK_DIV = 8,
  parameter int RD_WIN  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op,
  input  logic [DEV_W-1:0]  dev,
  input  logic              bcast,
  input  logic [REG_W-1:0]  reg_addr,
  input  logic [DAT_W-1:0]  wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DAT_W-1:0]  rdata,
  output logic              sck,
  output logic              cmd,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              sdi
);

  localparam int N_SLOTS = PKT_W * N_PKT;
  localparam int SLOT_W  = $clog2(N_SLOTS);
  localparam int PKT_BW  = $clog2(PKT_W);
  localparam logic [SLOT_W-1:0] SLOT_LAST   = SLOT_W'(N_SLOTS - 1);
  localparam logic [SLOT_W-1:0] SLOT_RD_END = SLOT_W'(3 * PKT_W - 1);
  localparam logic [SLOT_W-1:0] CMD_SLOTS   = SLOT_W'(2);

  logic rst_l;
  sra_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_l));

  sra_state_t        state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  sra_req_t          req_q, req_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [DAT_W-1:0]  rdata_q, rdata_d;

  logic run, fall_tick, slot_end;
  logic rx_clear, rx_sample, rx_fin, rx_bad;
  logic [DAT_W-1:0] rx_data;
  logic accept, is_rd;
  logic [PKT_W-1:0] pkt_word;
  logic [N_PKT > 1 ? $clog2(N_PKT)-1 : 0 : 0] pkt_sel;
  logic [PKT_BW-1:0] bit_sel;

  assign run       = (state_q != ST_IDLE);
  assign accept    = start && (state_q == ST_IDLE);
  assign is_rd     = (req_q.op == OP_READ);
  assign rx_sample = fall_tick && (state_q == ST_RX);

  sra_clkdiv #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_l), .run(run),
    .sck(sck), .fall_tick(fall_tick), .slot_end(slot_end)
  );

  sra_rx #(.WIN(RD_WIN), .DW(DAT_W)) u_rx (
    .clk(clk), .rst_n(rst_l), .clear(rx_clear), .sample(rx_sample),
    .sdi(sdi), .fin(rx_fin), .bad(rx_bad), .data(rx_data)
  );

  // Packet select and bit select from the slot counter.
  assign pkt_sel = slot_q[SLOT_W-1:PKT_BW];
  assign bit_sel = slot_q[PKT_BW-1:0];

  always_comb begin
    unique case (pkt_sel)
      2'd0:    pkt_word = req_word(req_q);
      2'd1:    pkt_word = PKT_W'(req_q.addr);
      2'd2:    pkt_word = is_rd ? '0 : req_q.wdata;
      default: pkt_word = '0;
    endcase
  end

  // Next-state logic.
  always_comb begin
    state_d  = state_q;
    slot_d   = slot_q;
    req_d    = req_q;
    done_d   = 1'b0;
    err_d    = err_q;
    rdata_d  = rdata_q;
    rx_clear = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if ((op == OP_READ) && bcast) begin
            done_d  = 1'b1;
            err_d   = 1'b1;
            rdata_d = '0;
          end else begin
            state_d  = ST_TX;
            slot_d   = '0;
            req_d    = '{op: op, dev: dev, bcast: bcast, addr: reg_addr, wdata: wdata};
            rx_clear = 1'b1;
          end
        end
      end
      ST_TX: begin
        if (slot_end) begin
          slot_d = slot_q + 1'b1;
          if (slot_q == SLOT_LAST) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            err_d   = 1'b0;
            rdata_d = '0;
          end else if (is_rd && (slot_q == SLOT_RD_END)) begin
            state_d = ST_RX;
          end
        end
      end
      ST_RX: begin
        if (slot_end) slot_d = slot_q + 1'b1;
        if (rx_fin) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = rx_bad;
          rdata_d = rx_bad ? '0 : rx_data;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      req_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      req_q   <= req_d;
      done_q  <= done_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign busy   = run;
  assign done   = done_q;
  assign err    = err_q;
  assign rdata  = rdata_q;
  assign cmd    = (state_q == ST_TX) && (slot_q < CMD_SLOTS);
  assign sdo_oe = (state_q != ST_RX);
  assign sdo    = (state_q == ST_TX) ? pkt_word[~bit_sel] : 1'b0;

endmodule

// File: rtl/sra_master_chk.sv
module sra_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  op,
  input logic        bcast,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [15:0] rdata,
  input logic        sck,
  input logic        cmd,
  input logic        sdo,
  input logic        sdo_oe
);

  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  a_r3_cmd_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |-> (busy && sdo_oe));

  a_r4_sdo_stable_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sck && $past(busy && !sck)) |-> $stable(sdo));

  a_r6_release_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> (busy && !cmd));

  a_r8_err_clears_data: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rdata == 16'h0000));

  a_r11_bcast_read_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (op == 4'h2) && bcast) |=> (done && err && !busy));

  a_r12_idle_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sdo_oe && !sdo && !cmd));

  a_r5_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind sra_master sra_master_chk i_sra_master_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bcast(bcast),
  .busy(busy), .done(done), .err(err), .rdata(rdata), .sck(sck),
  .cmd(cmd), .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/test_sra_master.sv
module test_sra_master;

  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;
  localparam int WIN  = 24;

  logic clk, rst_n, start, bcast, sdi;
  logic [3:0] op;
  logic [5:0] dev;
  logic [11:0] reg_addr;
  logic [15:0] wdata;
  logic busy, done, err, sck, cmd, sdo, sdo_oe;
  logic [15:0] rdata;

  sra_master #(.CLK_DIV(DIV), .RD_WIN(WIN)) i_sra_master (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dev(dev),
    .bcast(bcast), .reg_addr(reg_addr), .wdata(wdata), .busy(busy),
    .done(done), .err(err), .rdata(rdata), .sck(sck), .cmd(cmd),
    .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model state
  bit        model_on = 0;
  bit        pend = 0;
  bit        mactive = 0;
  bit        bc_now = 0;
  int        n, endn, kfin;
  bit        m_rd, m_bc, m_err;
  logic [63:0] m_bits;
  logic [15:0] m_rdata;
  // Return-frame device settings
  int        d_turn = 2;
  logic      d_stop = 1'b0;
  logic [15:0] d_data = 16'h0;
  int        busy_cnt = 0;

  always @(posedge clk) begin
    if (model_on && start && !mactive && !pend) begin
      pend   = 1;
      m_rd   = (op == 4'h2);
      m_bc   = bcast;
      m_bits = {op, dev, bcast, 5'b0, 4'b0, reg_addr, (op == 4'h2) ? 16'h0 : wdata, 16'h0};
      if (m_rd) begin
        if (d_turn + 17 <= WIN - 1) begin
          kfin  = d_turn + 17;
          m_err = d_stop;
        end else begin
          kfin  = WIN - 1;
          m_err = 1;
        end
        endn    = (48 + kfin) * DIV + HALF + 1;
        m_rdata = m_err ? 16'h0 : d_data;
      end else begin
        endn    = 64 * DIV;
        m_err   = 0;
        m_rdata = 16'h0;
      end
    end
  end

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (model_on) begin
      if (pend) begin
        pend = 0;
        if (m_rd && m_bc) bc_now = 1;
        else begin mactive = 1; n = 0; end
      end
      if (mactive) begin
        if (n == endn) begin
          chk(m_rd ? "R7 done" : "R5 done", done, 1);
          chk("R5 busy end", busy, 0);
          chk("R2 sck end", sck, 0);
          chk(m_rd ? "R7 rdata" : "R5 rdata", rdata, m_rdata);
          chk(m_rd ? ((d_turn + 17 > WIN - 1) ? "R9 err" : "R8 err") : "R5 err", err, m_err);
          chk("R12 idle oe", sdo_oe, 1);
          chk("R12 idle sdo", sdo, 0);
          mactive = 0;
          sdi = 1'b1;
        end else begin
          int slot, ph, k;
          slot = n / DIV;
          ph   = n % DIV;
          chk("R5 busy", busy, 1);
          chk("R2 sck", sck, (ph < HALF));
          chk("R3 cmd", cmd, (slot < 2));
          chk("R6 oe", sdo_oe, !(m_rd && slot >= 48));
          chk("R1 done low", done, 0);
          if (!(m_rd && slot >= 48))
            chk(slot < 16 ? "R4 req bit" : (m_rd ? "R6 bit" : "R5 bit"), sdo, m_bits[63 - slot]);
          k = slot - 48;
          if (!m_rd || k < 0)              sdi = 1'b1;
          else if (k < d_turn)             sdi = 1'b1;
          else if (k == d_turn)            sdi = 1'b0;
          else if (k <= d_turn + 16)       sdi = d_data[15 - (k - d_turn - 1)];
          else if (k == d_turn + 17)       sdi = d_stop;
          else                             sdi = 1'b1;
        end
        n++;
      end else if (bc_now) begin
        bc_now = 0;
        chk("R11 done", done, 1);
        chk("R11 err", err, 1);
        chk("R11 busy", busy, 0);
        chk("R11 sck", sck, 0);
        chk("R11 rdata", rdata, 0);
      end else begin
        chk("R12 busy", busy, 0);
        chk("R12 done", done, 0);
        chk("R2 sck idle", sck, 0);
        chk("R3 cmd idle", cmd, 0);
        chk("R12 oe", sdo_oe, 1);
        chk("R12 sdo", sdo, 0);
      end
    end
  end

  task automatic launch(input logic [3:0] o, input logic [5:0] d, input logic b,
                        input logic [11:0] a, input logic [15:0] w);
    @(negedge clk);
    op = o; dev = d; bcast = b; reg_addr = a; wdata = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(posedge clk);
  endtask

  task automatic wait_idle();
    while (mactive || pend || bc_now) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic txn(input logic [3:0] o, input logic [5:0] d, input logic b,
                     input logic [11:0] a, input logic [15:0] w);
    launch(o, d, b, a, w);
    wait_idle();
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 4'h0; dev = 6'h0; bcast = 1'b0;
    reg_addr = 12'h0; wdata = 16'h0; sdi = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 sck", sck, 0);
    chk("R1 cmd", cmd, 0);
    chk("R1 sdo", sdo, 0);
    chk("R1 oe", sdo_oe, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1;
    repeat (4) @(posedge clk);

    // R5: writes with different field patterns
    busy_cnt = 0;
    txn(4'h3, 6'h05, 1'b0, 12'hA5C, 16'h1234);
    chk("R5 busy length", busy_cnt, 64 * DIV);
    txn(4'hF, 6'h3F, 1'b1, 12'hFFF, 16'hFFFF);

    // R6 R7: good reads
    d_turn = 2; d_stop = 1'b0; d_data = 16'hBEEF;
    txn(4'h2, 6'h11, 1'b0, 12'h123, 16'h0);
    d_turn = 0; d_data = 16'h0001;
    txn(4'h2, 6'h00, 1'b0, 12'h001, 16'h0);
    d_turn = WIN - 18; d_data = 16'h8000;
    txn(4'h2, 6'h2A, 1'b0, 12'h800, 16'h0);

    // R8: trailing bit of 1
    d_turn = 1; d_stop = 1'b1; d_data = 16'h5A5A;
    txn(4'h2, 6'h07, 1'b0, 12'h0F0, 16'h0);

    // R9: frame does not fit the window
    d_turn = 10; d_stop = 1'b0; d_data = 16'h1111;
    txn(4'h2, 6'h07, 1'b0, 12'h0F0, 16'h0);

    // R11: broadcast read refused
    txn(4'h2, 6'h01, 1'b1, 12'h010, 16'h0);

    // R10: start during a write is ignored
    busy_cnt = 0;
    launch(4'h6, 6'h12, 1'b0, 12'h345, 16'hC3C3);
    repeat (100) @(posedge clk);
    d_turn = 2; d_stop = 1'b0; d_data = 16'hAAAA;
    launch(4'h2, 6'h01, 1'b1, 12'h777, 16'h0);
    launch(4'h2, 6'h02, 1'b0, 12'h777, 16'h0);
    wait_idle();
    chk("R10 busy length", busy_cnt, 64 * DIV);
    chk("R10 err after ignored start", err, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R5 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule